// File: doc/BRIEF.md
# Dual Parallel Port Register Interface

This block is the register front end of a two-port 8-bit parallel peripheral. A host reaches it through a two-bit register select and an 8-bit data bus, using single-cycle read and write strobes qualified by a chip select. Each port, A and B, has three registers: a data direction register, an output register and a control register. The data direction register sets which pins the port drives. The output register holds the value to drive.

One address per port is shared between the direction register and the port data. A select bit in that port's control register decides which of the two the address reaches. A read of port data merges two sources: driven bits come from the output register, and input bits come from the sampled pins. The same read also clears the port's two interrupt flags.

The flags are set by event pulses that arrive already detected. Each port drives an active-low interrupt request. A build-time option permutes the register select before decoding, for hosts that need the other address layout.

Top module: `pp_regif`

## Requirements
- R1: After reset every direction, output and control register is 0. Both flags of each port are 0. Each irq_x_n is 1 and each px_oe is 0. A read of offset 0 or 2 therefore returns the direction register, 0x00.
- R2: Offsets decode as 0 = port A data/direction, 1 = control A, 2 = port B data/direction, 3 = control B. Control bit 2 picks the target of the shared offset: 1 selects the output register, 0 selects the direction register.
- R3: With control bit 2 set, a port data read returns (out & ddr) | (pins & ~ddr). The pins are sampled into a register, so the read shows the pin value from one clock earlier.
- R4: A port data write stores all 8 bits unmasked. px_oe equals the direction register and px_out equals out & ddr. A later change of the direction register changes px_out in the next cycle.
- R5: A control write updates only bits 5..0. Bits 7 and 6 of the written byte are ignored.
- R6: A control read returns {flag1, flag2 & ~ctl[5], ctl[5:0]}. Bit 5 = 1 marks the second control line as an output, and bit 6 then reads 0. A flag2 that was set stays stored and reappears when bit 5 returns to 0.
- R7: A port data read with control bit 2 set clears both flags of that port on the read cycle. Control reads, direction reads and reads of the other port leave the flags unchanged.
- R8: An event pulse (x_evt1 or x_evt2) sets its flag on the next clock edge. When the pulse falls in the same cycle as a clearing read, the set wins.
- R9: irq_x_n is 0 exactly when (flag1 & ctl[0]) | (flag2 & ctl[3] & ~ctl[5]) holds for that port.
- R10: A read or write strobe without cs has no effect on any register or flag.
- R11: With ALT_ORDER = 1, raw select bit 0 chooses the port (1 = B) and raw bit 1 chooses the control register. Raw offsets 0,1,2,3 thus reach effective offsets 0,2,1,3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select qualifying rd and wr |
| rd | input | 1 | Register read strobe, one cycle |
| wr | input | 1 | Register write strobe, one cycle |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| pa_in | input | 8 | Port A pin inputs |
| pa_out | output | 8 | Port A pin drive value |
| pa_oe | output | 8 | Port A pin drive enables |
| pb_in | input | 8 | Port B pin inputs |
| pb_out | output | 8 | Port B pin drive value |
| pb_oe | output | 8 | Port B pin drive enables |
| a_evt1 | input | 1 | Port A first-line event pulse |
| a_evt2 | input | 1 | Port A second-line event pulse |
| b_evt1 | input | 1 | Port B first-line event pulse |
| b_evt2 | input | 1 | Port B second-line event pulse |
| irq_a_n | output | 1 | Port A interrupt request, active low |
| irq_b_n | output | 1 | Port B interrupt request, active low |

## Verification
The assertions assume that rd and wr each last exactly one cycle and are never raised together. They also assume that event pulses arrive already synchronised to clk. The stimulus drives every strobe and pulse for a single cycle, changing them on the falling edge only. It never overlaps a read with a write, though it does overlap an event with a clearing read on purpose. Pin values are set at least one clock before they are read, which respects the sampling stage.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned CTL_W  = 6;
  localparam int unsigned NPORT  = 2;
  localparam int unsigned SEL_W  = 2;

  localparam int unsigned CB_IRQ1_EN = 0;
  localparam int unsigned CB_OUT_SEL = 2;
  localparam int unsigned CB_IRQ2_EN = 3;
  localparam int unsigned CB_L2_OUT  = 5;

  typedef struct packed {
    logic is_ctl;
    logic port_b;
  } reg_sel_t;

  function automatic reg_sel_t map_offset(input logic [SEL_W-1:0] off, input logic alt);
    reg_sel_t s;
    if (alt) begin
      s.port_b = off[0];
      s.is_ctl = off[1];
    end else begin
      s.port_b = off[1];
      s.is_ctl = off[0];
    end
    return s;
  endfunction

  function automatic logic [DATA_W-1:0] merge_pins(input logic [DATA_W-1:0] outv,
                                                   input logic [DATA_W-1:0] dir,
                                                   input logic [DATA_W-1:0] pins);
    return (outv & dir) | (pins & ~dir);
  endfunction

  function automatic logic [DATA_W-1:0] status_byte(input logic f1, input logic f2,
                                                    input logic [CTL_W-1:0] ctl);
    return {f1, f2 & ~ctl[CB_L2_OUT], ctl};
  endfunction

  function automatic logic irq_active(input logic f1, input logic f2,
                                      input logic [CTL_W-1:0] ctl);
    return (f1 & ctl[CB_IRQ1_EN]) | (f2 & ctl[CB_IRQ2_EN] & ~ctl[CB_L2_OUT]);
  endfunction
endpackage

// File: rtl/pp_decode.sv
module pp_decode
  import pp_pkg::*;
#(
  parameter bit ALT_ORDER = 1'b0
) (
  input  logic             cs,
  input  logic             rd,
  input  logic             wr,
  input  logic [SEL_W-1:0] addr,
  output logic             rd_stb,
  output logic             wr_stb,
  output logic [NPORT-1:0] sel_data,
  output logic [NPORT-1:0] sel_ctl,
  output logic             port_idx
);
  reg_sel_t s;
  assign s        = map_offset(addr, ALT_ORDER);
  assign rd_stb   = cs & rd;
  assign wr_stb   = cs & wr;
  assign port_idx = s.port_b;

  for (genvar p = 0; p < NPORT; p++) begin : g_sel
    assign sel_data[p] = (int'(s.port_b) == p) && !s.is_ctl;
    assign sel_ctl[p]  = (int'(s.port_b) == p) &&  s.is_ctl;
  end
endmodule

// File: rtl/pp_port.sv
module pp_port
  import pp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_data,
  input  logic              sel_ctl,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] pin_in,
  input  logic              evt1,
  input  logic              evt2,
  output logic [DATA_W-1:0] rd_val,
  output logic [DATA_W-1:0] pin_out,
  output logic [DATA_W-1:0] pin_oe,
  output logic              irq_n,
  output logic              flag1_q,
  output logic              flag2_q,
  output logic              data_rd,
  output logic              ctl_wr,
  output logic [DATA_W-1:0] ddr_q,
  output logic [CTL_W-1:0]  ctl_q
);
  logic [DATA_W-1:0] out_q;
  logic [DATA_W-1:0] pin_q;
  logic out_sel, data_wr, ddr_wr;

  assign out_sel = ctl_q[CB_OUT_SEL];
  assign data_wr = wr_stb & sel_data &  out_sel;
  assign ddr_wr  = wr_stb & sel_data & ~out_sel;
  assign ctl_wr  = wr_stb & sel_ctl;
  assign data_rd = rd_stb & sel_data &  out_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ddr_q   <= '0;
      out_q   <= '0;
      ctl_q   <= '0;
      pin_q   <= '0;
      flag1_q <= 1'b0;
      flag2_q <= 1'b0;
    end else begin
      pin_q <= pin_in;
      if (ddr_wr)  ddr_q <= wdata;
      if (data_wr) out_q <= wdata;
      if (ctl_wr)  ctl_q <= wdata[CTL_W-1:0];
      flag1_q <= evt1 | (flag1_q & ~data_rd);
      flag2_q <= evt2 | (flag2_q & ~data_rd);
    end
  end

  always_comb begin
    if (sel_ctl)      rd_val = status_byte(flag1_q, flag2_q, ctl_q);
    else if (out_sel) rd_val = merge_pins(out_q, ddr_q, pin_q);
    else              rd_val = ddr_q;
  end

  assign pin_out = out_q & ddr_q;
  assign pin_oe  = ddr_q;
  assign irq_n   = ~irq_active(flag1_q, flag2_q, ctl_q);
endmodule

// File: rtl/pp_regif.sv
module pp_regif
  import pp_pkg::*;
#(
  parameter bit ALT_ORDER = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic [SEL_W-1:0]  addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] pa_in,
  output logic [DATA_W-1:0] pa_out,
  output logic [DATA_W-1:0] pa_oe,
  input  logic [DATA_W-1:0] pb_in,
  output logic [DATA_W-1:0] pb_out,
  output logic [DATA_W-1:0] pb_oe,
  input  logic              a_evt1,
  input  logic              a_evt2,
  input  logic              b_evt1,
  input  logic              b_evt2,
  output logic              irq_a_n,
  output logic              irq_b_n
);
  logic rd_stb, wr_stb, port_idx;
  logic [NPORT-1:0] sel_data, sel_ctl;
  logic [NPORT-1:0] evt1_v, evt2_v, irq_n_v, flag1, flag2, data_rd, ctl_wr;
  logic [NPORT-1:0][DATA_W-1:0] pin_in_v, pin_out_v, pin_oe_v, rd_val_v, ddr_q;
  logic [NPORT-1:0][CTL_W-1:0]  ctl_q;

  assign pin_in_v = {pb_in, pa_in};
  assign evt1_v   = {b_evt1, a_evt1};
  assign evt2_v   = {b_evt2, a_evt2};

  pp_decode #(.ALT_ORDER(ALT_ORDER)) u_dec (
    .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .rd_stb(rd_stb), .wr_stb(wr_stb),
    .sel_data(sel_data), .sel_ctl(sel_ctl), .port_idx(port_idx)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    pp_port u_port (
      .clk(clk), .rst_n(rst_n),
      .sel_data(sel_data[p]), .sel_ctl(sel_ctl[p]),
      .rd_stb(rd_stb), .wr_stb(wr_stb), .wdata(wdata),
      .pin_in(pin_in_v[p]), .evt1(evt1_v[p]), .evt2(evt2_v[p]),
      .rd_val(rd_val_v[p]), .pin_out(pin_out_v[p]), .pin_oe(pin_oe_v[p]),
      .irq_n(irq_n_v[p]), .flag1_q(flag1[p]), .flag2_q(flag2[p]),
      .data_rd(data_rd[p]), .ctl_wr(ctl_wr[p]),
      .ddr_q(ddr_q[p]), .ctl_q(ctl_q[p])
    );
  end

  assign rdata   = rd_val_v[port_idx];
  assign pa_out  = pin_out_v[0];
  assign pa_oe   = pin_oe_v[0];
  assign pb_out  = pin_out_v[1];
  assign pb_oe   = pin_oe_v[1];
  assign irq_a_n = irq_n_v[0];
  assign irq_b_n = irq_n_v[1];
endmodule

// File: rtl/pp_regif_chk.sv
module pp_regif_chk
  import pp_pkg::*;
(
  input logic                          clk,
  input logic                          rst_n,
  input logic                          cs,
  input logic [DATA_W-1:0]             wdata,
  input logic [NPORT-1:0]              evt1,
  input logic [NPORT-1:0]              flag1,
  input logic [NPORT-1:0]              flag2,
  input logic [NPORT-1:0]              data_rd,
  input logic [NPORT-1:0]              ctl_wr,
  input logic [NPORT-1:0][DATA_W-1:0]  ddr_q,
  input logic [NPORT-1:0][CTL_W-1:0]   ctl_q,
  input logic                          irq_a_n
);
  // R7: a clearing read drops flags of port A
  a_r7_clear_a: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd[0] && !evt1[0]) |=> (!flag1[0] && !flag2[0]));
  // R7: same for port B
  a_r7_clear_b: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd[1] && !evt1[1]) |=> !flag1[1]);
  // R8: an event always leaves its flag set
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    evt1[0] |=> flag1[0]);
  // R10: no state change without chip select
  a_r10_no_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> ($stable(ddr_q) && $stable(ctl_q)));
  // R5: control write keeps only the low bits
  a_r5_ctl_write: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr[0] |=> (ctl_q[0] == $past(wdata[CTL_W-1:0])));
  // R9: enabled first flag requests an interrupt
  a_r9_irq_a: assert property (@(posedge clk) disable iff (!rst_n)
    (flag1[0] && ctl_q[0][CB_IRQ1_EN]) |-> !irq_a_n);
endmodule

bind pp_regif pp_regif_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .wdata(wdata),
  .evt1(evt1_v), .flag1(flag1), .flag2(flag2),
  .data_rd(data_rd), .ctl_wr(ctl_wr),
  .ddr_q(ddr_q), .ctl_q(ctl_q), .irq_a_n(irq_a_n)
);

// File: tb/test_pp_regif.sv
module test_pp_regif;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, cs_alt = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, pa_in = '0, pb_in = '0;
  logic [3:0] evt = '0;
  logic [7:0] rdata, pa_out, pa_oe, pb_out, pb_oe;
  logic [7:0] rdata_alt, pa_out_alt, pa_oe_alt, pb_out_alt, pb_oe_alt;
  logic irq_a_n, irq_b_n, irq_a_n_alt, irq_b_n_alt;
  int errors = 0, checks = 0;
  logic [7:0] v;

  always #10 clk = ~clk;

  pp_regif i_pp_regif (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .a_evt1(evt[0]), .a_evt2(evt[1]), .b_evt1(evt[2]), .b_evt2(evt[3]),
    .irq_a_n(irq_a_n), .irq_b_n(irq_b_n));

  pp_regif #(.ALT_ORDER(1'b1)) i_pp_regif_alt (
    .clk(clk), .rst_n(rst_n), .cs(cs_alt), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata_alt), .pa_in(pa_in), .pa_out(pa_out_alt),
    .pa_oe(pa_oe_alt), .pb_in(pb_in), .pb_out(pb_out_alt), .pb_oe(pb_oe_alt),
    .a_evt1(1'b0), .a_evt2(1'b0), .b_evt1(1'b0), .b_evt2(1'b0),
    .irq_a_n(irq_a_n_alt), .irq_b_n(irq_b_n_alt));

  // {op(1=read), addr, data, expected}
  localparam logic [18:0] VEC [16] = '{
    {1'b1, 2'd0, 8'h00, 8'h00},  // R1 direction after reset
    {1'b1, 2'd1, 8'h00, 8'h00},  // R1 control after reset
    {1'b0, 2'd0, 8'hF0, 8'h00},
    {1'b1, 2'd0, 8'h00, 8'hF0},  // R2 direction
    {1'b0, 2'd1, 8'h04, 8'h00},
    {1'b1, 2'd1, 8'h00, 8'h04},  // R2 control A
    {1'b0, 2'd0, 8'h5A, 8'h00},
    {1'b1, 2'd0, 8'h00, 8'h55},  // R3 merge A
    {1'b0, 2'd3, 8'hFF, 8'h00},
    {1'b1, 2'd3, 8'h00, 8'h3F},  // R5 control B
    {1'b0, 2'd3, 8'h00, 8'h00},
    {1'b0, 2'd2, 8'h0F, 8'h00},
    {1'b1, 2'd2, 8'h00, 8'h0F},  // R2 direction B
    {1'b0, 2'd3, 8'h04, 8'h00},
    {1'b0, 2'd2, 8'hC3, 8'h00},
    {1'b1, 2'd2, 8'h00, 8'h33}   // R3 merge B
  };

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr_reg(input logic alt, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cs = !alt; cs_alt = alt; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; cs_alt = 1'b0; wr = 1'b0;
  endtask

  task automatic rd_reg(input logic alt, input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    cs = !alt; cs_alt = alt; rd = 1'b1; addr = a;
    #2 d = alt ? rdata_alt : rdata;
    @(negedge clk);
    cs = 1'b0; cs_alt = 1'b0; rd = 1'b0;
  endtask

  task automatic pulse(input logic [3:0] m);
    @(negedge clk); evt = m;
    @(negedge clk); evt = '0;
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    pa_in = 8'hA5; pb_in = 8'h3C;
    repeat (3) @(negedge clk);
    chk(pa_oe, 8'h00, "R1 pa_oe");
    chk({7'd0, irq_a_n}, 8'h01, "R1 irq_a_n");
    rst_n = 1'b1;

    foreach (VEC[i]) begin
      if (VEC[i][18]) begin
        rd_reg(1'b0, VEC[i][17:16], v);
        chk(v, VEC[i][7:0], $sformatf("vector %0d (R1/R2/R3/R5)", i));
      end else wr_reg(1'b0, VEC[i][17:16], VEC[i][15:8]);
    end

    // R4 drive and unmasked store
    chk(pa_out, 8'h50, "R4 pa_out");
    chk(pa_oe, 8'hF0, "R4 pa_oe");
    wr_reg(1'b0, 2'd1, 8'h00);
    wr_reg(1'b0, 2'd0, 8'hFF);
    chk(pa_out, 8'h5A, "R4 unmasked after ddr change");
    wr_reg(1'b0, 2'd1, 8'h04);

    // R5 top bits ignored
    wr_reg(1'b0, 2'd1, 8'hC4);
    rd_reg(1'b0, 2'd1, v); chk(v, 8'h04, "R5 status bits read-only");

    // R10 write without cs
    @(negedge clk); cs = 1'b0; wr = 1'b1; addr = 2'd1; wdata = 8'h3F;
    @(negedge clk); wr = 1'b0;
    rd_reg(1'b0, 2'd1, v); chk(v, 8'h04, "R10 no cs");

    // R6 R7 R9 flags
    wr_reg(1'b0, 2'd1, 8'h0D);
    pulse(4'b0011);
    rd_reg(1'b0, 2'd1, v); chk(v, 8'hCD, "R6 flags visible");
    chk({7'd0, irq_a_n}, 8'h00, "R9 irq asserted");
    rd_reg(1'b0, 2'd1, v); chk(v, 8'hCD, "R7 control read keeps flags");
    rd_reg(1'b0, 2'd2, v);
    rd_reg(1'b0, 2'd1, v); chk(v, 8'hCD, "R7 other port read keeps flags");
    rd_reg(1'b0, 2'd0, v);
    rd_reg(1'b0, 2'd1, v); chk(v, 8'h0D, "R7 data read clears");
    chk({7'd0, irq_a_n}, 8'h01, "R9 irq released");

    // R6 second line as output hides flag2
    wr_reg(1'b0, 2'd1, 8'h2D);
    pulse(4'b0010);
    rd_reg(1'b0, 2'd1, v); chk(v, 8'h2D, "R6 flag2 hidden");
    chk({7'd0, irq_a_n}, 8'h01, "R9 no irq with line2 output");
    wr_reg(1'b0, 2'd1, 8'h0D);
    rd_reg(1'b0, 2'd1, v); chk(v, 8'h4D, "R6 flag2 reappears");
    chk({7'd0, irq_a_n}, 8'h00, "R9 irq from flag2");
    rd_reg(1'b0, 2'd0, v);

    // R8 set wins over clear
    wr_reg(1'b0, 2'd1, 8'h04);
    @(negedge clk); cs = 1'b1; rd = 1'b1; addr = 2'd0; evt = 4'b0001;
    @(negedge clk); cs = 1'b0; rd = 1'b0; evt = '0;
    rd_reg(1'b0, 2'd1, v); chk(v, 8'h84, "R8 set wins");
    chk({7'd0, irq_a_n}, 8'h01, "R9 disabled enable");

    // R9 port B
    wr_reg(1'b0, 2'd3, 8'h05);
    pulse(4'b0100);
    chk({7'd0, irq_b_n}, 8'h00, "R9 port B irq");

    // R11 alternate ordering
    wr_reg(1'b1, 2'd1, 8'h77);
    wr_reg(1'b1, 2'd2, 8'h04);
    rd_reg(1'b1, 2'd2, v); chk(v, 8'h04, "R11 raw 2 is control A");
    rd_reg(1'b1, 2'd1, v); chk(v, 8'h77, "R11 raw 1 is port B");
    chk(pb_oe_alt, 8'h77, "R11 pb_oe");
    chk(pa_oe_alt, 8'h00, "R11 pa_oe");

    // R1 reset returns everything to zero
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk(pa_oe, 8'h00, "R1 pa_oe after reset");
    chk({7'd0, irq_b_n}, 8'h01, "R1 irq_b_n after reset");
    rst_n = 1'b1;
    rd_reg(1'b0, 2'd1, v); chk(v, 8'h00, "R1 control after reset");
    rd_reg(1'b0, 2'd0, v); chk(v, 8'h00, "R1 direction after reset");

    summary();
    $finish;
  end
endmodule